// File: doc/BRIEF.md
# Instruction Fetch Decoder

This block turns a raw window of instruction bytes, read starting at the program counter, into the decoded fields of a single instruction of a small 32-bit ISA whose instructions are one to six bytes long. The leading byte selects the operation and its variant. The leading byte also decides whether a register-specifier byte follows and whether a 32-bit little-endian constant follows. The decoder extracts both register specifiers and the constant, computes the address of the next sequential instruction, and marks encodings that are not legal.

The decoded result is registered, so every output reflects the window and PC presented one clock edge earlier. The fetch stage of a processor supplies the PC and a window of `2 + WORD_BYTES` bytes, with the byte at the PC in the least significant position. It uses the returned next address to advance. It uses the invalid flag to stop or trap.

Top module: `fd_fetch_decode`

## Requirements
- R1: On each rising clock edge outside reset, `icode_o` takes the upper nibble of window byte 0 and `ifun_o` takes its lower nibble. Window byte k sits at `win_i[8k+7:8k]`.
- R2: Operation codes 0x0 to 0xB are defined. Any code from 0xC to 0xF sets `invalid_o`.
- R3: Code 0x6 (ALU operation) accepts function 0 to 3. Code 0x7 (conditional jump) accepts function 0 to 6. Every other defined code accepts only function 0. Any other function value sets `invalid_o`.
- R4: For a valid instruction, `need_reg_o` is 1 exactly for codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB.
- R5: For a valid instruction, `need_const_o` is 1 exactly for codes 0x3, 0x4, 0x5, 0x7 and 0x8.
- R6: When a register byte is present, `ra_o` is the upper nibble of byte 1 and `rb_o` is its lower nibble. When the register byte is absent, both read 0x8, which means no register.
- R7: `valc_o` is assembled little-endian. It comes from bytes 2 to 5 when both a register byte and a constant are present, and from bytes 1 to 4 when only a constant is present. It is zero when there is no constant.
- R8: `valp_o` equals PC + 1, plus 1 when a register byte is present, plus 4 when a constant is present, modulo 2^32.
- R9: When `invalid_o` is 1, both need flags are 0, `ra_o` and `rb_o` are 0x8, `valc_o` is 0, and `valp_o` is PC + 1.
- R10: While `rst` is high, the outputs are set at the clock edge to a decoded no-op at address zero: icode 0, ifun 0, ra and rb 0x8, valc 0, valp 0, and all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the instruction's first byte |
| win_i | input | 48 | Instruction bytes at the PC; byte 0 is in the low bits |
| icode_o | output | 4 | Operation code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier, 0x8 when absent |
| rb_o | output | 4 | Second register specifier, 0x8 when absent |
| valc_o | output | 32 | Constant word, 0 when absent |
| valp_o | output | 32 | Address of the next sequential instruction |
| need_reg_o | output | 1 | A register byte is present |
| need_const_o | output | 1 | A constant word is present |
| invalid_o | output | 1 | The encoding is illegal |

## Verification
Two situations are hard to reach from the ports. The first is the next-address computation wrapping past the top of the 32-bit space. The second is the narrow band of function codes that are legal only for the ALU and jump opcodes. The stimulus sweeps every possible leading byte, so it covers every pairing of operation code and function code. Each leading byte is combined with four PCs, one of which is two bytes below 2^32, so the 2-, 5- and 6-byte forms all wrap. Each combination also carries a different pseudo-random tail, so the constant and register bytes change between patterns. A literal move-immediate encoding anchors the little-endian byte order against a known value.

// File: rtl/fd_pkg.sv
package fd_pkg;

    localparam logic [3:0] REG_NONE = 4'h8;

    localparam logic [3:0] OP_NOP   = 4'h0;
    localparam logic [3:0] OP_HALT  = 4'h1;
    localparam logic [3:0] OP_RRMOV = 4'h2;
    localparam logic [3:0] OP_IRMOV = 4'h3;
    localparam logic [3:0] OP_RMMOV = 4'h4;
    localparam logic [3:0] OP_MRMOV = 4'h5;
    localparam logic [3:0] OP_ALU   = 4'h6;
    localparam logic [3:0] OP_JCC   = 4'h7;
    localparam logic [3:0] OP_CALL  = 4'h8;
    localparam logic [3:0] OP_RET   = 4'h9;
    localparam logic [3:0] OP_PUSH  = 4'hA;
    localparam logic [3:0] OP_POP   = 4'hB;

    localparam logic [3:0] ALU_FN_LAST = 4'h3;
    localparam logic [3:0] JCC_FN_LAST = 4'h6;

    typedef struct packed {
        logic need_reg;
        logic need_const;
        logic invalid;
    } op_class_t;

    function automatic logic op_known(input logic [3:0] ic);
        return ic <= OP_POP;
    endfunction

    function automatic logic op_has_reg(input logic [3:0] ic);
        case (ic)
            OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
            OP_ALU, OP_PUSH, OP_POP: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic op_has_const(input logic [3:0] ic);
        case (ic)
            OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_JCC, OP_CALL: return 1'b1;
            default:                                       return 1'b0;
        endcase
    endfunction

    function automatic logic fn_legal(input logic [3:0] ic, input logic [3:0] fn);
        case (ic)
            OP_ALU:  return fn <= ALU_FN_LAST;
            OP_JCC:  return fn <= JCC_FN_LAST;
            default: return fn == 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/fd_classify.sv
module fd_classify
    import fd_pkg::*;
(
    input  logic [3:0] icode,
    input  logic [3:0] ifun,
    output op_class_t  cls
);
    logic bad;

    always_comb begin
        bad            = !op_known(icode) || !fn_legal(icode, ifun);
        cls.invalid    = bad;
        cls.need_reg   = !bad && op_has_reg(icode);
        cls.need_const = !bad && op_has_const(icode);
    end
endmodule

// File: rtl/fd_fields.sv
module fd_fields
    import fd_pkg::*;
#(
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WIN_BYTES = WORD_BYTES + 2,
    localparam int unsigned WIN_W     = 8 * WIN_BYTES,
    localparam int unsigned WORD_W    = 8 * WORD_BYTES
) (
    input  logic [WIN_W-1:0]  win,
    input  op_class_t         cls,
    output logic [3:0]        ra,
    output logic [3:0]        rb,
    output logic [WORD_W-1:0] valc
);
    logic [WORD_W-1:0] const_near;
    logic [WORD_W-1:0] const_far;

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_bytes
        assign const_near[8*g +: 8] = win[8*(g+1) +: 8];
        assign const_far[8*g +: 8]  = win[8*(g+2) +: 8];
    end

    always_comb begin
        if (cls.need_reg) begin
            ra = win[15:12];
            rb = win[11:8];
        end else begin
            ra = REG_NONE;
            rb = REG_NONE;
        end
        if (!cls.need_const)
            valc = '0;
        else if (cls.need_reg)
            valc = const_far;
        else
            valc = const_near;
    end
endmodule

// File: rtl/fd_next_pc.sv
module fd_next_pc
    import fd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc,
    input  op_class_t         cls,
    output logic [ADDR_W-1:0] valp
);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] WLEN = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] reg_len;
    logic [ADDR_W-1:0] const_len;

    always_comb begin
        reg_len   = cls.need_reg   ? ONE  : '0;
        const_len = cls.need_const ? WLEN : '0;
        valp      = pc + ONE + reg_len + const_len;
    end
endmodule

// File: rtl/fd_fetch_decode.sv
module fd_fetch_decode
    import fd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WIN_W     = 8 * (WORD_BYTES + 2),
    localparam int unsigned WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [WIN_W-1:0]  win_i,
    output logic [3:0]        icode_o,
    output logic [3:0]        ifun_o,
    output logic [3:0]        ra_o,
    output logic [3:0]        rb_o,
    output logic [WORD_W-1:0] valc_o,
    output logic [ADDR_W-1:0] valp_o,
    output logic              need_reg_o,
    output logic              need_const_o,
    output logic              invalid_o
);
    logic [3:0]        icode_d;
    logic [3:0]        ifun_d;
    op_class_t         cls_d;
    logic [3:0]        ra_d;
    logic [3:0]        rb_d;
    logic [WORD_W-1:0] valc_d;
    logic [ADDR_W-1:0] valp_d;

    assign icode_d = win_i[7:4];
    assign ifun_d  = win_i[3:0];

    fd_classify u_classify (
        .icode (icode_d),
        .ifun  (ifun_d),
        .cls   (cls_d)
    );

    fd_fields #(.WORD_BYTES(WORD_BYTES)) u_fields (
        .win  (win_i),
        .cls  (cls_d),
        .ra   (ra_d),
        .rb   (rb_d),
        .valc (valc_d)
    );

    fd_next_pc #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_next_pc (
        .pc   (pc_i),
        .cls  (cls_d),
        .valp (valp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            icode_o      <= OP_NOP;
            ifun_o       <= 4'h0;
            ra_o         <= REG_NONE;
            rb_o         <= REG_NONE;
            valc_o       <= '0;
            valp_o       <= '0;
            need_reg_o   <= 1'b0;
            need_const_o <= 1'b0;
            invalid_o    <= 1'b0;
        end else begin
            icode_o      <= icode_d;
            ifun_o       <= ifun_d;
            ra_o         <= ra_d;
            rb_o         <= rb_d;
            valc_o       <= valc_d;
            valp_o       <= valp_d;
            need_reg_o   <= cls_d.need_reg;
            need_const_o <= cls_d.need_const;
            invalid_o    <= cls_d.invalid;
        end
    end
endmodule

// File: rtl/fd_fetch_decode_chk.sv
module fd_fetch_decode_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WIN_W     = 8 * (WORD_BYTES + 2),
    localparam int unsigned WORD_W    = 8 * WORD_BYTES
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] pc_i,
    input logic [WIN_W-1:0]  win_i,
    input logic [3:0]        icode_o,
    input logic [3:0]        ifun_o,
    input logic [3:0]        ra_o,
    input logic [3:0]        rb_o,
    input logic [WORD_W-1:0] valc_o,
    input logic [ADDR_W-1:0] valp_o,
    input logic              need_reg_o,
    input logic              need_const_o,
    input logic              invalid_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_NIBBLE_SPLIT: assert property (@(posedge clk) disable iff (rst)
        armed |-> (icode_o == $past(win_i[7:4]) && ifun_o == $past(win_i[3:0]))); // R1

    AST_HIGH_CODE_BAD: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(win_i[7:4]) > 4'hB) |-> invalid_o); // R2

    AST_PLAIN_FN_BAD: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(win_i[7:4]) < 4'h6 && $past(win_i[3:0]) != 4'h0) |-> invalid_o); // R3

    AST_NO_REG_FIELDS: assert property (@(posedge clk) disable iff (rst)
        !need_reg_o |-> (ra_o == 4'h8 && rb_o == 4'h8)); // R6

    AST_NO_CONST_ZERO: assert property (@(posedge clk) disable iff (rst)
        !need_const_o |-> valc_o == '0); // R7

    AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (rst)
        armed |-> valp_o == $past(pc_i) + ADDR_W'(1) + ADDR_W'(need_reg_o)
                  + (need_const_o ? ADDR_W'(WORD_BYTES) : '0)); // R8

    AST_INVALID_CLEAN: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> (!need_reg_o && !need_const_o && valc_o == '0)); // R9

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (icode_o == 4'h0 && ra_o == 4'h8 && rb_o == 4'h8 && valp_o == '0
                 && !invalid_o && !need_reg_o && !need_const_o)); // R10
endmodule

bind fd_fetch_decode fd_fetch_decode_chk #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk(clk), .rst(rst), .pc_i(pc_i), .win_i(win_i),
    .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
    .valc_o(valc_o), .valp_o(valp_o), .need_reg_o(need_reg_o),
    .need_const_o(need_const_o), .invalid_o(invalid_o)
);

// File: tb/test_fd_fetch_decode.sv
module test_fd_fetch_decode;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic [47:0] win_i = '0;
    logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
    logic [31:0] valc_o, valp_o;
    logic        need_reg_o, need_const_o, invalid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fd_fetch_decode i_fd_fetch_decode (
        .clk(clk), .rst(rst), .pc_i(pc_i), .win_i(win_i),
        .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
        .valc_o(valc_o), .valp_o(valp_o), .need_reg_o(need_reg_o),
        .need_const_o(need_const_o), .invalid_o(invalid_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state();
        chk("R10", "icode", 32'(icode_o), 32'h0);
        chk("R10", "ifun", 32'(ifun_o), 32'h0);
        chk("R10", "ra", 32'(ra_o), 32'h8);
        chk("R10", "rb", 32'(rb_o), 32'h8);
        chk("R10", "valc", valc_o, 32'h0);
        chk("R10", "valp", valp_o, 32'h0);
        chk("R10", "flags", {29'h0, need_reg_o, need_const_o, invalid_o}, 32'h0);
    endtask

    // Drive at a falling edge, let one rising edge capture, compare at the next falling edge.
    task automatic apply_and_check(input logic [31:0] pc, input logic [47:0] win);
        logic [3:0]  hi, lo;
        logic        bad, hreg, hcon;
        logic [31:0] exp_c, exp_p;
        string       bad_req;
        hi = win[7:4];
        lo = win[3:0];
        bad_req = (hi > 4'hB) ? "R2" : "R3";
        if (hi > 4'hB)       bad = 1'b1;
        else if (hi == 4'h6) bad = lo > 4'h3;
        else if (hi == 4'h7) bad = lo > 4'h6;
        else                 bad = lo != 4'h0;
        hreg = !bad && (hi inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
        hcon = !bad && (hi inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
        if (!hcon)     exp_c = 32'h0;
        else if (hreg) exp_c = {win[47:40], win[39:32], win[31:24], win[23:16]};
        else           exp_c = {win[39:32], win[31:24], win[23:16], win[15:8]};
        exp_p = pc + 32'd1 + (hreg ? 32'd1 : 32'd0) + (hcon ? 32'd4 : 32'd0);
        pc_i  = pc;
        win_i = win;
        @(negedge clk);
        chk("R1", "icode", 32'(icode_o), 32'(hi));
        chk("R1", "ifun", 32'(ifun_o), 32'(lo));
        chk(bad_req, "invalid", 32'(invalid_o), 32'(bad));
        chk(bad ? "R9" : "R4", "need_reg", 32'(need_reg_o), 32'(hreg));
        chk(bad ? "R9" : "R5", "need_const", 32'(need_const_o), 32'(hcon));
        chk(bad ? "R9" : "R6", "ra", 32'(ra_o), hreg ? 32'(win[15:12]) : 32'h8);
        chk(bad ? "R9" : "R6", "rb", 32'(rb_o), hreg ? 32'(win[11:8]) : 32'h8);
        chk(bad ? "R9" : "R7", "valc", valc_o, exp_c);
        chk(bad ? "R9" : "R8", "valp", valp_o, exp_p);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pcs [4];
        pcs[0] = 32'h0000_0000;
        pcs[1] = 32'h0000_0100;
        pcs[2] = 32'hFFFF_FFFE;
        pcs[3] = 32'h7FFF_FFFC;

        repeat (3) @(negedge clk);
        check_reset_state();                      // R10
        rst = 1'b0;

        // Known move-immediate encoding: rB = 2, constant 0x0000abcd (R7)
        apply_and_check(32'h0000_0040, 48'h0000_abcd_8230);
        chk("R7", "literal valc", valc_o, 32'h0000_abcd);
        chk("R6", "literal rb", 32'(rb_o), 32'h2);
        chk("R8", "literal valp", valp_o, 32'h0000_0046);

        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 256; b++) begin
                logic [47:0] w;
                w[7:0] = 8'(b);
                for (int k = 1; k < 6; k++)
                    w[8*k +: 8] = 8'((b * 7 + k * 37 + p * 91 + k * k * 13) & 8'hFF);
                apply_and_check(pcs[p], w);
            end
        end

        // Reset asserted mid-run returns the decoded no-op (R10)
        win_i = 48'h0000_1234_5630;
        rst   = 1'b1;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule